// File: doc/BRIEF.md
# Sequential Dial Combination Lock

This block is the decision logic of a rotary combination lock. Each dial operation reaches it as a single event: a direction bit, a dial position from 0 to 39, and a one-cycle valid strobe. The block opens only when three operations arrive in the right order: right to 13, then left to 22, then right to 3. The same values in another order, or with the wrong direction, do not open it.

Progress is held in a two-bit stage register with four named values: idle, first step done, second step done, and open. The stage is output so that the surrounding logic can see how far the user has got. The unlock output is high only in the open stage. A relock pulse or a synchronous reset returns the block to idle. Any wrong operation restarts the sequence. If that wrong operation is itself the first step, it counts as a new first step.

Top module: `dial_sequence_lock`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle: `stage` = 0 and `unlocked` = 0 after the clock edge.
- R2: `stage` encodes 0 = idle, 1 = right-13 done, 2 = right-13 then left-22 done, 3 = open. `unlocked` is 1 exactly when `stage` is 3.
- R3: In idle, a valid operation with `op_right` = 1 (1 means right, 0 means left) and `op_value` = 13 moves `stage` to 1 on the next edge.
- R4: In stage 1, a valid operation left (`op_right` = 0) to 22 moves `stage` to 2.
- R5: In stage 2, a valid operation right to 3 moves `stage` to 3, which opens the lock.
- R6: In stages 0 to 2, a valid operation that is not the expected next step returns `stage` to 0. This includes a right value paired with the wrong direction.
- R7: R7 is the exception to R6: a non-matching valid operation that is right-13 moves `stage` to 1.
- R8: A cycle with `op_valid` = 0 and `relock` = 0 leaves `stage` unchanged.
- R9: In stage 3, valid operations are ignored. The lock stays open until `relock` or `rst`.
- R10: `relock` = 1 moves `stage` to 0 on the next edge from any stage. It takes priority over a valid operation in the same cycle.
- R11: An `op_value` above 39 never matches any step. It is treated as a non-matching operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| relock | input | 1 | Returns the lock to idle on the next edge |
| op_valid | input | 1 | One-cycle strobe marking a dial operation |
| op_right | input | 1 | Direction of the operation: 1 right, 0 left |
| op_value | input | 6 | Dial position of the operation |
| stage | output | 2 | Progress through the sequence (0..3) |
| unlocked | output | 1 | High while the lock is open |

## Verification
The hardest case to reach is a wrong operation arriving deep in the sequence that is itself right-13. To reach it, the stimulus first takes the lock to stage 1 or stage 2. It then sends right-13 and expects the lock to land in stage 1, not idle. It then continues with left-22 to show that the restarted sequence can still open the lock. A relock that arrives together with a valid operation is also driven on purpose, so that the priority between the two can be seen. Out-of-range values whose low bits look like a step code, such as 53, are driven as well.

// File: rtl/dlock_pkg.sv
package dlock_pkg;
    localparam int DIAL_W = 6;
    localparam int NSTEPS = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2,
        ST_OPEN  = 2'd3
    } stage_t;

    typedef struct packed {
        logic              right;
        logic [DIAL_W-1:0] value;
    } dial_op_t;

    function automatic logic op_equals(dial_op_t op, logic dir,
                                       logic [DIAL_W-1:0] val,
                                       logic [DIAL_W-1:0] vmax);
        return (op.right == dir) && (op.value == val) && (op.value <= vmax);
    endfunction
endpackage

// File: rtl/dlock_step_match.sv
module dlock_step_match
    import dlock_pkg::*;
#(
    parameter logic              DIR0 = 1'b1,
    parameter logic [DIAL_W-1:0] VAL0 = 6'd13,
    parameter logic              DIR1 = 1'b0,
    parameter logic [DIAL_W-1:0] VAL1 = 6'd22,
    parameter logic              DIR2 = 1'b1,
    parameter logic [DIAL_W-1:0] VAL2 = 6'd3,
    parameter logic [DIAL_W-1:0] VMAX = 6'd39
) (
    input  stage_t   cur,
    input  dial_op_t op,
    output logic     hit_next,
    output logic     hit_first
);
    localparam logic [NSTEPS-1:0]        DIRS = {DIR2, DIR1, DIR0};
    localparam logic [NSTEPS*DIAL_W-1:0] VALS = {VAL2, VAL1, VAL0};

    logic [NSTEPS:0] step_hit;

    for (genvar g = 0; g < NSTEPS; g++) begin : g_step
        assign step_hit[g] = op_equals(op, DIRS[g], VALS[g*DIAL_W +: DIAL_W], VMAX);
    end
    assign step_hit[NSTEPS] = 1'b0;

    always_comb begin
        hit_next  = step_hit[cur];
        hit_first = step_hit[0];
    end
endmodule

// File: rtl/dlock_next_stage.sv
module dlock_next_stage
    import dlock_pkg::*;
(
    input  stage_t cur,
    input  logic   relock,
    input  logic   valid,
    input  logic   hit_next,
    input  logic   hit_first,
    output stage_t nxt
);
    always_comb begin
        nxt = cur;
        if (relock) begin
            nxt = ST_IDLE;
        end else if (valid && cur != ST_OPEN) begin
            if (hit_next)       nxt = stage_t'(cur + 2'd1);
            else if (hit_first) nxt = ST_ONE;
            else                nxt = ST_IDLE;
        end
    end
endmodule

// File: rtl/dial_sequence_lock.sv
module dial_sequence_lock
    import dlock_pkg::*;
#(
    parameter logic              DIR0 = 1'b1,
    parameter logic [DIAL_W-1:0] VAL0 = 6'd13,
    parameter logic              DIR1 = 1'b0,
    parameter logic [DIAL_W-1:0] VAL1 = 6'd22,
    parameter logic              DIR2 = 1'b1,
    parameter logic [DIAL_W-1:0] VAL2 = 6'd3,
    parameter logic [DIAL_W-1:0] VMAX = 6'd39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              relock,
    input  logic              op_valid,
    input  logic              op_right,
    input  logic [DIAL_W-1:0] op_value,
    output logic [1:0]        stage,
    output logic              unlocked
);
    stage_t   cur_q, nxt;
    dial_op_t op;
    logic     hit_next, hit_first;

    assign op = '{right: op_right, value: op_value};

    dlock_step_match #(
        .DIR0(DIR0), .VAL0(VAL0), .DIR1(DIR1), .VAL1(VAL1),
        .DIR2(DIR2), .VAL2(VAL2), .VMAX(VMAX)
    ) u_match (
        .cur(cur_q), .op(op), .hit_next(hit_next), .hit_first(hit_first)
    );

    dlock_next_stage u_next (
        .cur(cur_q), .relock(relock), .valid(op_valid),
        .hit_next(hit_next), .hit_first(hit_first), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= ST_IDLE;
        else     cur_q <= nxt;
    end

    assign stage    = cur_q;
    assign unlocked = (cur_q == ST_OPEN);
endmodule

// File: rtl/dlock_checker.sv
module dlock_checker
    import dlock_pkg::*;
#(
    parameter logic              DIR0 = 1'b1,
    parameter logic [DIAL_W-1:0] VAL0 = 6'd13
) (
    input logic              clk,
    input logic              rst,
    input logic              relock,
    input logic              op_valid,
    input logic              op_right,
    input logic [DIAL_W-1:0] op_value,
    input logic [1:0]        stage,
    input logic              unlocked
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (stage == 2'd0 && !unlocked));

    p_unlock_open_r2: assert property (@(posedge clk) disable iff (rst)
        unlocked |-> stage == 2'd3);

    p_first_step_r3: assert property (@(posedge clk) disable iff (rst)
        (stage == 2'd0 && op_valid && !relock && op_right == DIR0 && op_value == VAL0)
        |=> stage == 2'd1);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !relock) |=> $stable(stage));

    p_open_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (stage == 2'd3 && !relock) |=> stage == 2'd3);

    p_relock_idle_r10: assert property (@(posedge clk) disable iff (rst)
        relock |=> stage == 2'd0);
endmodule

bind dial_sequence_lock dlock_checker #(.DIR0(DIR0), .VAL0(VAL0)) u_dlock_chk (
    .clk(clk), .rst(rst), .relock(relock), .op_valid(op_valid),
    .op_right(op_right), .op_value(op_value), .stage(stage), .unlocked(unlocked)
);

// File: tb/tb_dial_sequence_lock.sv
module tb_dial_sequence_lock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       relock = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_right = 1'b0;
    logic [5:0] op_value = 6'd0;
    logic [1:0] stage;
    logic       unlocked;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int mstage = 0;
    bit done = 0;
    int exp_dir[3] = '{1, 0, 1};
    int exp_val[3] = '{13, 22, 3};

    always #5 clk = ~clk;

    dial_sequence_lock dut (
        .clk(clk), .rst(rst), .relock(relock), .op_valid(op_valid),
        .op_right(op_right), .op_value(op_value), .stage(stage), .unlocked(unlocked)
    );

    function automatic int model_next(int s, bit r, bit rl, bit v, bit dir, int val);
        if (r || rl) return 0;
        if (!v || s == 3) return s;
        if (val <= 39 && int'(dir) == exp_dir[s] && val == exp_val[s]) return s + 1;
        if (dir && val == 13) return 1;
        return 0;
    endfunction

    task automatic check(string tag);
        checks++;
        if (int'(stage) != mstage || unlocked != (mstage == 3)) begin
            errors++;
            $display("FAIL %s stage=%0d unlocked=%0d expected stage=%0d unlocked=%0d",
                     tag, stage, unlocked, mstage, (mstage == 3));
        end
    endtask

    task automatic step(string tag, bit r, bit rl, bit v, bit dir, int val);
        rst = r; relock = rl; op_valid = v; op_right = dir; op_value = 6'(val);
        @(posedge clk);
        mstage = model_next(mstage, r, rl, v, dir, val);
        @(negedge clk);
        rst = 0; relock = 0; op_valid = 0;
        check(tag);
    endtask

    task automatic op(string tag, bit dir, int val);
        step(tag, 0, 0, 1, dir, val);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        step("R1 reset", 1, 0, 0, 0, 0);
        step("R1 reset", 1, 0, 1, 1, 13);
        idle("R8 hold idle");
        op("R3 right13", 1, 13);
        idle("R8 hold one");
        op("R4 left22", 0, 22);
        idle("R8 hold two");
        idle("R8 hold two");
        op("R5 right3", 1, 3);
        idle("R2 open");
        op("R9 ignore in open", 0, 5);
        op("R9 ignore right13 in open", 1, 13);
        step("R10 relock beats op", 0, 1, 1, 1, 13);
        op("R6 wrong dir first", 0, 13);
        op("R3 right13", 1, 13);
        op("R6 right22 wrong dir", 1, 22);
        op("R3 right13", 1, 13);
        op("R7 right13 again", 1, 13);
        op("R4 left22", 0, 22);
        op("R7 right13 from two", 1, 13);
        op("R4 left22", 0, 22);
        op("R6 left3 wrong dir", 0, 3);
        op("R11 right53", 1, 53);
        op("R11 right61", 1, 61);
        op("R3 right13", 1, 13);
        op("R4 left22", 0, 22);
        op("R11 right43", 1, 43);
        op("R3 right13", 1, 13);
        op("R4 left22", 0, 22);
        op("R5 right3", 1, 3);
        step("R10 relock from open", 0, 1, 0, 0, 0);
        op("R3 right13", 1, 13);
        op("R4 left22", 0, 22);
        op("R5 right3", 1, 3);
        step("R1 reset from open", 1, 0, 0, 0, 0);
        step("R10 relock idle", 0, 1, 0, 0, 0);
        op("R6 left22 at idle", 0, 22);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000 && !done) begin
                done = 1;
                checks++;
                errors++;
                $display("FAIL watchdog expired stage=%0d expected finish", stage);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end
endmodule